// File: doc/BRIEF.md
# Pipelined Sum of Absolute Differences

This block scores how closely two rows of pixels match, the inner step of block-matching motion estimation. Each operation presents two 64-bit words holding eight unsigned 8-bit pixels each, plus a 64-bit running total. The block subtracts each pixel of the second word from the pixel in the same lane of the first word, takes the absolute value of each of the eight differences, adds the eight magnitudes together, and adds that sum to the running total.

The work is split over three register stages: magnitudes first, then a balanced reduction tree, then the wide accumulation. A new operation can be issued on every clock, and a valid flag travels alongside the data so that gaps in the input stream reappear as gaps at the output. The caller chains rows by feeding each result back as the next running total.

Top module: `sad_pipe`

## Requirements
- R1: `out_valid` equals the `in_valid` sampled exactly three rising clock edges earlier (counting only edges with `rst_n` high).
- R2: Lane i occupies bits [8i+7:8i] of each source and is treated as unsigned. A valid result equals `acc_in` plus the sum over all eight lanes of |a_i - b_i|, taken from the same issue cycle. An all-255 word against an all-zero word adds 2040.
- R3: Operations issued on consecutive cycles produce results on consecutive cycles, each matching its own operands.
- R4: The 64-bit addition wraps modulo 2^64; a total of 2^64-1 plus a sum of 2040 yields 2039.
- R5: While `rst_n` is low at a rising edge, every pipeline valid bit clears; operations in flight are dropped and `out_valid` stays low until new operations have passed all three stages.
- R6: Swapping the two sources gives the same result, and identical sources return `acc_in` unchanged.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low three cycles later, without disturbing the results around it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| src_a | input | 64 | Eight unsigned pixels, minuend side |
| src_b | input | 64 | Eight unsigned pixels, subtrahend side |
| acc_in | input | 64 | Running total to which the sum is added |
| out_valid | output | 1 | Result present on `sad_out` |
| sad_out | output | 64 | Running total plus the eight absolute differences |

## Verification
A wrong magnitude in one lane, for instance one that loses its sign handling, shows up as a result that differs from the arithmetic sum three cycles after the offending operands, and only for pixel pairs where the second exceeds the first; sweeping one lane through all 256 values against a set of edge values in every lane position reveals it within one sweep. A corrupted reduction node or a dropped carry in the accumulation stage changes `sad_out` in the same third cycle, and the wrap case catches a narrowed accumulator. A stuck or misrouted valid bit shows at `out_valid` in the first bubble or reset, three cycles after the stimulus.

// File: rtl/sad_pkg.sv
// Package: shared defaults for the sum-of-absolute-differences pipeline.
// Assumes: lane count is a power of two and at least two.
package sad_pkg;
    parameter int unsigned DEF_LANES = 8;   // pixels per source word
    parameter int unsigned DEF_PIX_W = 8;   // bits per pixel
    parameter int unsigned DEF_ACC_W = 64;  // running-total width

    // Width needed to hold the sum of LANES magnitudes of PIX_W bits.
    function automatic int unsigned sum_width(input int unsigned lanes,
                                              input int unsigned pix_w);
        return pix_w + $clog2(lanes);
    endfunction
endpackage

// File: rtl/sad_absdiff_stage.sv
// Stage 1: per-lane absolute difference of unsigned pixels.
// Each lane forms a PIX_W+1 bit difference, then negates it when negative.
// Assumes: data registers need no reset; only the valid bit is reset.
module sad_absdiff_stage #(
    parameter int unsigned LANES = sad_pkg::DEF_LANES,
    parameter int unsigned PIX_W = sad_pkg::DEF_PIX_W,
    parameter int unsigned ACC_W = sad_pkg::DEF_ACC_W,
    localparam int unsigned WORD_W = LANES * PIX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic [WORD_W-1:0]      a_i,
    input  logic [WORD_W-1:0]      b_i,
    input  logic [ACC_W-1:0]       acc_i,
    output logic                   vld_o,
    output logic [WORD_W-1:0]      mag_o,
    output logic [ACC_W-1:0]       acc_o
);
    logic [WORD_W-1:0] mag_d;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [PIX_W:0] diff;
        // Purpose: signed difference of one lane, then its magnitude.
        always_comb begin
            diff = {1'b0, a_i[ln*PIX_W +: PIX_W]} - {1'b0, b_i[ln*PIX_W +: PIX_W]};
            if (diff[PIX_W]) begin
                mag_d[ln*PIX_W +: PIX_W] = PIX_W'(-diff);
            end else begin
                mag_d[ln*PIX_W +: PIX_W] = diff[PIX_W-1:0];
            end
        end
    end

    // Purpose: valid bit of stage 1, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Purpose: capture magnitudes and pass the running total along.
    always_ff @(posedge clk) begin
        mag_o <= mag_d;
        acc_o <= acc_i;
    end
endmodule

// File: rtl/sad_reduce_stage.sv
// Stage 2: balanced adder tree over the lane magnitudes.
// The tree is stored heap-style: leaves at LANES..2*LANES-1, root at 1.
// Assumes: LANES is a power of two, at least two.
module sad_reduce_stage #(
    parameter int unsigned LANES = sad_pkg::DEF_LANES,
    parameter int unsigned PIX_W = sad_pkg::DEF_PIX_W,
    parameter int unsigned ACC_W = sad_pkg::DEF_ACC_W,
    localparam int unsigned WORD_W = LANES * PIX_W,
    localparam int unsigned SUM_W  = sad_pkg::sum_width(LANES, PIX_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic [WORD_W-1:0]      mag_i,
    input  logic [ACC_W-1:0]       acc_i,
    output logic                   vld_o,
    output logic [SUM_W-1:0]       sum_o,
    output logic [ACC_W-1:0]       acc_o
);
    logic [SUM_W-1:0] node [1:2*LANES-1];

    for (genvar lf = 0; lf < LANES; lf++) begin : g_leaf
        // Purpose: zero-extend one magnitude into a tree leaf.
        assign node[LANES+lf] = {{(SUM_W-PIX_W){1'b0}}, mag_i[lf*PIX_W +: PIX_W]};
    end

    for (genvar nd = 1; nd < LANES; nd++) begin : g_node
        // Purpose: one interior adder of the reduction tree.
        assign node[nd] = node[2*nd] + node[2*nd+1];
    end

    // Purpose: valid bit of stage 2, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Purpose: capture the tree root and the running total.
    always_ff @(posedge clk) begin
        sum_o <= node[1];
        acc_o <= acc_i;
    end
endmodule

// File: rtl/sad_accum_stage.sv
// Stage 3: add the reduced sum to the running total, modulo 2^ACC_W.
// Assumes: ACC_W is wider than the sum width.
module sad_accum_stage #(
    parameter int unsigned LANES = sad_pkg::DEF_LANES,
    parameter int unsigned PIX_W = sad_pkg::DEF_PIX_W,
    parameter int unsigned ACC_W = sad_pkg::DEF_ACC_W,
    localparam int unsigned SUM_W = sad_pkg::sum_width(LANES, PIX_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic [SUM_W-1:0]       sum_i,
    input  logic [ACC_W-1:0]       acc_i,
    output logic                   vld_o,
    output logic [ACC_W-1:0]       res_o
);
    // Purpose: valid bit of stage 3, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Purpose: wide accumulation; the carry out of the top bit is dropped.
    always_ff @(posedge clk) begin
        res_o <= acc_i + {{(ACC_W-SUM_W){1'b0}}, sum_i};
    end
endmodule

// File: rtl/sad_pipe.sv
// Top: three-stage sum of absolute differences with accumulation.
// Accepts one operation per clock; results appear three cycles later.
// Assumes: synchronous active-low reset clears valid bits only.
module sad_pipe #(
    parameter int unsigned LANES = sad_pkg::DEF_LANES,
    parameter int unsigned PIX_W = sad_pkg::DEF_PIX_W,
    parameter int unsigned ACC_W = sad_pkg::DEF_ACC_W,
    localparam int unsigned WORD_W = LANES * PIX_W,
    localparam int unsigned SUM_W  = sad_pkg::sum_width(LANES, PIX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic [ACC_W-1:0]  acc_in,
    output logic              out_valid,
    output logic [ACC_W-1:0]  sad_out
);
    logic              s1_vld, s2_vld;
    logic [WORD_W-1:0] s1_mag;
    logic [ACC_W-1:0]  s1_acc, s2_acc;
    logic [SUM_W-1:0]  s2_sum;

    sad_absdiff_stage #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) i_stage1 (
        .clk(clk), .rst_n(rst_n),
        .vld_i(in_valid), .a_i(src_a), .b_i(src_b), .acc_i(acc_in),
        .vld_o(s1_vld), .mag_o(s1_mag), .acc_o(s1_acc)
    );

    sad_reduce_stage #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) i_stage2 (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s1_vld), .mag_i(s1_mag), .acc_i(s1_acc),
        .vld_o(s2_vld), .sum_o(s2_sum), .acc_o(s2_acc)
    );

    sad_accum_stage #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) i_stage3 (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s2_vld), .sum_i(s2_sum), .acc_i(s2_acc),
        .vld_o(out_valid), .res_o(sad_out)
    );
endmodule

// File: rtl/sad_pipe_chk.sv
// Checker: port-level properties of sad_pipe, bound into every instance.
// A saturating count of cycles out of reset keeps 3-deep history lookups
// from reaching back into or before reset.
module sad_pipe_chk #(
    parameter int unsigned LANES = sad_pkg::DEF_LANES,
    parameter int unsigned PIX_W = sad_pkg::DEF_PIX_W,
    parameter int unsigned ACC_W = sad_pkg::DEF_ACC_W,
    localparam int unsigned WORD_W = LANES * PIX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] src_a,
    input logic [WORD_W-1:0] src_b,
    input logic [ACC_W-1:0]  acc_in,
    input logic              out_valid,
    input logic [ACC_W-1:0]  sad_out
);
    localparam logic [ACC_W-1:0] MAX_SUM = ACC_W'(LANES * ((1 << PIX_W) - 1));

    logic [1:0] warm_cnt;
    logic       warm;

    // Purpose: count edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd3);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    p_sum_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |-> ((sad_out - $past(acc_in, 3)) <= MAX_SUM));

    p_reset_clear_r5: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_equal_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && ($past(src_a, 3) == $past(src_b, 3)))
        |-> (sad_out == $past(acc_in, 3)));

    p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(in_valid, 3)) |-> !out_valid);
endmodule

bind sad_pipe sad_pipe_chk #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) i_sad_pipe_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .sad_out(sad_out)
);

// File: tb/test_sad_pipe.sv
`timescale 1ns/1ps
// Bench: sweeps pixel values through every lane, runs random streams with
// bubbles and a mid-stream reset, and compares against arithmetic sums.
module test_sad_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_a = '0, src_b = '0, acc_in = '0;
    logic        out_valid;
    logic [63:0] sad_out;

    int n_cmp = 0;
    int n_bad = 0;

    // Expected pipeline, index 0 newest; modelled from the three-cycle latency.
    logic        p_v [3];
    logic [63:0] p_d [3];

    sad_pipe i_sad_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .sad_out(sad_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [63:0] model(input logic [63:0] a, b, acc);
        int s = 0;
        for (int i = 0; i < 8; i++) begin
            int x = int'(a[8*i +: 8]);
            int y = int'(b[8*i +: 8]);
            s += (x > y) ? (x - y) : (y - x);
        end
        return acc + 64'(s);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One clock: compare outputs of the last edge, drive, advance the model.
    task automatic step(input logic rn, input logic v, input logic [63:0] a, b, acc,
                        input string tag);
        @(negedge clk);
        check(out_valid === p_v[2], {tag, " valid"}, 64'(out_valid), 64'(p_v[2]));
        if (p_v[2])
            check(sad_out === p_d[2], {tag, " value"}, sad_out, p_d[2]);
        rst_n = rn; in_valid = v; src_a = a; src_b = b; acc_in = acc;
        @(posedge clk);
        if (!rn) begin
            for (int k = 0; k < 3; k++) p_v[k] = 1'b0;
        end else begin
            p_v[2] = p_v[1]; p_d[2] = p_d[1];
            p_v[1] = p_v[0]; p_d[1] = p_d[0];
            p_v[0] = v;      p_d[0] = model(a, b, acc);
        end
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, '0, '0, '0, tag);
    endtask

    initial begin
        #(100000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 3; k++) begin p_v[k] = 1'b0; p_d[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: reset state
        check(out_valid === 1'b0, "R5 reset state", 64'(out_valid), 64'd0);

        // R2: maximum difference in every lane adds 2040
        step(1'b1, 1'b1, {8{8'hFF}}, '0, 64'd0, "R2");
        drain("R2");
        // R6: swapped operands and equal operands
        step(1'b1, 1'b1, 64'h0102_0304_F0E0_D0C0, 64'h8070_6050_0000_FFFF, 64'd77, "R6");
        step(1'b1, 1'b1, 64'h8070_6050_0000_FFFF, 64'h0102_0304_F0E0_D0C0, 64'd77, "R6");
        step(1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 64'd12345, "R6");
        // R4: wrap of the running total
        step(1'b1, 1'b1, {8{8'hFF}}, '0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        step(1'b1, 1'b1, '0, {8{8'hFF}}, 64'hFFFF_FFFF_FFFF_F900, "R4");
        drain("R4");

        // R3: back-to-back sweep, one lane walks 0..255 against edge values
        for (int ln = 0; ln < 8; ln++) begin
            for (int e = 0; e < 6; e++) begin
                logic [7:0] ev;
                case (e)
                    0: ev = 8'd0;   1: ev = 8'd1;   2: ev = 8'd127;
                    3: ev = 8'd128; 4: ev = 8'd254; default: ev = 8'd255;
                endcase
                for (int x = 0; x < 256; x += (ln == 0) ? 1 : 17) begin
                    logic [63:0] a = 64'h5A5A_5A5A_5A5A_5A5A;
                    logic [63:0] b = 64'h5A5A_5A5A_5A5A_5A5A;
                    a[8*ln +: 8] = 8'(x);
                    b[8*ln +: 8] = ev;
                    step(1'b1, 1'b1, a, b, 64'(x * 1000 + e), "R3");
                end
            end
        end
        drain("R3");

        // R7: random stream with bubbles
        for (int k = 0; k < 2000; k++) begin
            step(1'b1, 1'(($urandom % 3) != 0),
                 {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "R7");
        end
        drain("R7");

        // R5: reset while operations are in flight
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b1, {$urandom, $urandom}, {$urandom, $urandom}, 64'd5, "R5");
        step(1'b0, 1'b1, {8{8'h11}}, '0, 64'd1, "R5");
        step(1'b0, 1'b1, {8{8'h22}}, '0, 64'd2, "R5");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, '0, '0, '0, "R5");
        step(1'b1, 1'b1, {8{8'h10}}, {8{8'h20}}, 64'd9, "R1");
        drain("R1");

        finish_run();
    end
endmodule